// File: doc/BRIEF.md
# Circular Audio Delay Buffer Controller

This block turns a stream of audio conversions into a delayed copy of that stream. It keeps the history in one or two external serial byte-wide RAM chips, which it drives as an SPI master. On each accepted sample tick it keeps the upper eight bits of a 10-bit conversion and writes that byte at the current write position of a circular buffer. In the same sample period it then reads back an older byte and presents it on a parallel output, together with a valid pulse one cycle long.

The delay offset comes from an 8-bit setting scaled by a 3-bit full-scale range code. A strap sampled once after reset sets the buffer length: one chip, or two chips joined into one contiguous buffer. Two tick inputs carry the two sample rates, and a level input picks which one is obeyed. Each chip holds `2**CHIP_AW` bytes. `CHIP_AW` must be at least 7, and the default of 15 matches 32768-byte parts.

The control state machine has four states. S_CFG is entered from reset and always moves to S_IDLE after one cycle, latching the strap. S_IDLE moves to S_WRITE on a tick from the selected line. S_WRITE moves to S_READ when the write frame completes. S_READ moves back to S_IDLE when the read frame completes, and presents the byte as it does so. The serial engine has its own three states. E_IDLE moves to E_RISE on a start request. E_RISE always moves to E_FALL. E_FALL moves to E_IDLE after the last bit, and otherwise back to E_RISE.

Top module: `audio_delay_ctrl`

## Requirements
- R1: While reset is held, `out_valid` is 0, both RAM chip selects are high and `spi_sclk` is low.
- R2: A write frame is 32 bits, sent MSB first with the clock idle low and data changed on falling edges. It is the opcode 8'h02, then a 16-bit address whose low `CHIP_AW` bits are the chip-local position and whose upper bits are zero, then the sample byte `adc_word[9:2]`.
- R3: After the write frame completes and its chip select has gone high, a read frame follows in the same sample period. The read frame is opcode 8'h03, then the 16-bit address, then 8 clocks during which `spi_miso` is sampled on rising edges, MSB first. No chip select is low while the block is idle.
- R4: The write pointer starts at 0 after reset and advances by one for each sample. It wraps to 0 at the buffer length, so the oldest bytes are overwritten.
- R5: The strap is sampled in the first cycle after reset. With the strap at 0 the buffer is `2**CHIP_AW` bytes and `ram2_cs_n` is never asserted. With the strap at 1 the buffer is `2**(CHIP_AW+1)` bytes: buffer positions with bit `CHIP_AW` clear go to the chip behind `ram1_cs_n`, and the others go to the chip behind `ram2_cs_n`.
- R6: Range code n (0 to 7) selects a full-scale length of buffer_length >> (7 - n), so code 7 spans the whole buffer.
- R7: The delay offset is (delay_code × full-scale length) >> 8, and the read position is (write position − offset) modulo the buffer length. A delay code of 0 returns the byte written in the same period.
- R8: With `rate_fast` at 0 only `tick_slow` starts a sample period, and with it at 1 only `tick_fast` does. A tick on the line that is not selected causes no bus activity and does not move the write pointer.
- R9: `out_valid` is high for exactly one cycle, 130 clock edges after the edge that accepts the tick, and `out_sample` then holds the byte read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| adc_word | input | 10 | Raw conversion; bits 9:2 are stored |
| delay_code | input | 8 | Delay setting, 0 to 255 of full scale |
| range_code | input | 3 | Full-scale range select, bit 0 least significant |
| rate_fast | input | 1 | Selects which tick line is obeyed |
| tick_slow | input | 1 | Sample tick at the lower rate |
| tick_fast | input | 1 | Sample tick at the higher rate |
| ram_cnt_strap | input | 1 | Chip-count strap: 1 means two RAM chips |
| spi_miso | input | 1 | Serial data from the RAM chips |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the RAM chips |
| ram1_cs_n | output | 1 | Active-low select for the first chip |
| ram2_cs_n | output | 1 | Active-low select for the second chip |
| out_sample | output | 8 | Delayed sample byte |
| out_valid | output | 1 | One-cycle strobe for `out_sample` |

## Verification
Each write frame takes 64 edges after the accepting edge, and the read frame starts on the next edge and takes another 64. The delayed byte therefore appears 130 edges after acceptance. The bench counts edges from the tick to `out_valid` at falling clock edges, checks that exact count and the byte, and then checks that the strobe has dropped one edge later. The RAM model updates its returned bit one system edge after each serial rising edge, which places each data bit before the block samples it. When a tick on the unselected line should have no effect, the bench watches for a fixed window and then confirms through the following delayed samples that the write pointer did not move.

// File: rtl/adly_pkg.sv
`timescale 1ns/1ps
package adly_pkg;
    typedef enum logic [1:0] {S_CFG, S_IDLE, S_WRITE, S_READ} ctl_state_t;
    typedef enum logic [1:0] {E_IDLE, E_RISE, E_FALL} eng_state_t;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam int         ADDR_FIELD_W = 16;
endpackage

// File: rtl/adly_addr_calc.sv
`timescale 1ns/1ps
module adly_addr_calc #(
    parameter int CHIP_AW = 15
) (
    input  logic [CHIP_AW:0]   wptr,
    input  logic [7:0]         delay_code,
    input  logic [2:0]         range_code,
    input  logic               two_ram,
    output logic [CHIP_AW:0]   offset,
    output logic [CHIP_AW+1:0] fs_len,
    output logic [CHIP_AW:0]   raddr
);
    localparam int PTR_W = CHIP_AW + 1;
    localparam int LW    = PTR_W + 1;

    logic [LW-1:0]    buf_len;
    logic [LW+7:0]    prod;
    logic [PTR_W-1:0] mask;
    logic [8:0]       unused_prod;

    always_comb begin
        buf_len = two_ram ? (LW'(1) << PTR_W) : (LW'(1) << CHIP_AW);
        mask    = two_ram ? {PTR_W{1'b1}} : {1'b0, {CHIP_AW{1'b1}}};
        fs_len  = buf_len >> (3'd7 - range_code);
        prod    = (LW+8)'(delay_code) * (LW+8)'(fs_len);
        offset  = prod[PTR_W+7:8];
        raddr   = (wptr - offset) & mask;
    end

    assign unused_prod = {prod[LW+7], prod[7:0]};
endmodule

// File: rtl/adly_spi_engine.sv
`timescale 1ns/1ps
module adly_spi_engine
    import adly_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               active,
    output logic               done,
    output logic [7:0]         rx_byte
);
    localparam int CW = $clog2(FRAME_W);

    eng_state_t         state_q, state_d;
    logic [CW-1:0]      cnt_q;
    logic [FRAME_W-1:0] tx_q;
    logic               last_bit;

    assign last_bit = (cnt_q == CW'(FRAME_W - 1));
    assign mosi     = tx_q[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= E_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE:  if (start) state_d = E_RISE;
            E_RISE:  state_d = E_FALL;
            E_FALL:  state_d = last_bit ? E_IDLE : E_RISE;
            default: state_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tx_q    <= '0;
            rx_byte <= '0;
            sclk    <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                E_IDLE: if (start) begin
                    tx_q   <= frame;
                    cnt_q  <= '0;
                    active <= 1'b1;
                end
                E_RISE: begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end
                E_FALL: begin
                    sclk <= 1'b0;
                    if (last_bit) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        tx_q  <= tx_q << 1;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> active);

    // R3
    done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && !sclk));
endmodule

// File: rtl/audio_delay_ctrl.sv
`timescale 1ns/1ps
module audio_delay_ctrl
    import adly_pkg::*;
#(
    parameter int CHIP_AW = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [9:0] adc_word,
    input  logic [7:0] delay_code,
    input  logic [2:0] range_code,
    input  logic       rate_fast,
    input  logic       tick_slow,
    input  logic       tick_fast,
    input  logic       ram_cnt_strap,
    input  logic       spi_miso,
    output logic       spi_sclk,
    output logic       spi_mosi,
    output logic       ram1_cs_n,
    output logic       ram2_cs_n,
    output logic [7:0] out_sample,
    output logic       out_valid
);
    localparam int PTR_W   = CHIP_AW + 1;
    localparam int FRAME_W = 16 + ADDR_FIELD_W;
    localparam int PAD_W   = ADDR_FIELD_W - CHIP_AW;

    ctl_state_t         state_q, state_d;
    logic               two_ram_q, sel2_q;
    logic [PTR_W-1:0]   wptr_q, raddr_q, raddr_calc, offset, ptr_mask;
    logic [PTR_W:0]     fs_len;
    logic               tick_sel, eng_start, eng_active, eng_done;
    logic [FRAME_W-1:0] frame;
    logic [7:0]         eng_rx;
    logic [1:0]         unused_lsb;

    assign unused_lsb = adc_word[1:0];
    assign tick_sel   = rate_fast ? tick_fast : tick_slow;
    assign ptr_mask   = two_ram_q ? {PTR_W{1'b1}} : {1'b0, {CHIP_AW{1'b1}}};

    adly_addr_calc #(.CHIP_AW(CHIP_AW)) u_addr (
        .wptr       (wptr_q),
        .delay_code (delay_code),
        .range_code (range_code),
        .two_ram    (two_ram_q),
        .offset     (offset),
        .fs_len     (fs_len),
        .raddr      (raddr_calc)
    );

    always_comb begin
        eng_start = 1'b0;
        frame     = {OP_READ, {PAD_W{1'b0}}, raddr_q[CHIP_AW-1:0], 8'h00};
        if (state_q == S_IDLE) begin
            eng_start = tick_sel;
            frame     = {OP_WRITE, {PAD_W{1'b0}}, wptr_q[CHIP_AW-1:0], adc_word[9:2]};
        end else if (state_q == S_WRITE) begin
            eng_start = eng_done;
        end
    end

    adly_spi_engine #(.FRAME_W(FRAME_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .frame   (frame),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .active  (eng_active),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    assign ram1_cs_n = !(eng_active && !sel2_q);
    assign ram2_cs_n = !(eng_active && sel2_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CFG;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CFG:   state_d = S_IDLE;
            S_IDLE:  if (tick_sel) state_d = S_WRITE;
            S_WRITE: if (eng_done) state_d = S_READ;
            S_READ:  if (eng_done) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            two_ram_q  <= 1'b0;
            sel2_q     <= 1'b0;
            wptr_q     <= '0;
            raddr_q    <= '0;
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                S_CFG: two_ram_q <= ram_cnt_strap;
                S_IDLE: if (tick_sel) begin
                    sel2_q  <= wptr_q[CHIP_AW];
                    raddr_q <= raddr_calc;
                end
                S_WRITE: if (eng_done) sel2_q <= raddr_q[CHIP_AW];
                S_READ: if (eng_done) begin
                    out_sample <= eng_rx;
                    out_valid  <= 1'b1;
                    wptr_q     <= (wptr_q + 1'b1) & ptr_mask;
                end
            endcase
        end
    end

    // R3
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (ram1_cs_n && ram2_cs_n));

    // R4
    wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wptr_q == (($past(wptr_q) + 1'b1) & ptr_mask)));

    // R5
    single_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_ram_q && state_q != S_CFG) |-> ram2_cs_n);

    // R7
    offset_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_CFG) |-> ({1'b0, offset} < fs_len));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/sim_audio_delay_ctrl.sv
`timescale 1ns/1ps
module sim_audio_delay_ctrl;
    localparam int CAW = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] adc_word = '0;
    logic [7:0] delay_code = '0;
    logic [2:0] range_code = '0;
    logic       rate_fast = 1'b0;
    logic       tick_slow = 1'b0;
    logic       tick_fast = 1'b0;
    logic       ram_cnt_strap = 1'b0;
    logic       spi_miso;
    logic       spi_sclk, spi_mosi, ram1_cs_n, ram2_cs_n, out_valid;
    logic [7:0] out_sample;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    audio_delay_ctrl #(.CHIP_AW(CAW)) u0 (
        .clk(clk), .rst_n(rst_n), .adc_word(adc_word), .delay_code(delay_code),
        .range_code(range_code), .rate_fast(rate_fast), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .ram_cnt_strap(ram_cnt_strap), .spi_miso(spi_miso),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .ram1_cs_n(ram1_cs_n),
        .ram2_cs_n(ram2_cs_n), .out_sample(out_sample), .out_valid(out_valid)
    );

    // RAM model: two chips of 2**CAW bytes, serial mode 0
    logic [7:0]  mem [0:255];
    logic        sclk_prev;
    int          bc;
    logic [31:0] sh;
    logic [23:0] lat;
    logic        lat_chip;
    int          bad_frames;
    int          ram2_low;
    logic [31:0] full;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
            bc <= 0; sclk_prev <= 1'b0; bad_frames <= 0; ram2_low <= 0;
            sh <= '0; lat <= '0; lat_chip <= 1'b0;
        end else begin
            sclk_prev <= spi_sclk;
            if (!ram2_cs_n) ram2_low <= ram2_low + 1;
            if (ram1_cs_n && ram2_cs_n) begin
                bc <= 0;
            end else if (spi_sclk && !sclk_prev) begin
                full = {sh[30:0], spi_mosi};
                sh <= full;
                bc <= bc + 1;
                if (bc == 23) begin
                    lat      <= full[23:0];
                    lat_chip <= !ram2_cs_n;
                end
                if (bc == 31) begin
                    if (full[23:8+CAW] != 0) bad_frames <= bad_frames + 1;
                    if (full[31:24] == 8'h02)
                        mem[{!ram2_cs_n, full[8+CAW-1:8]}] <= full[7:0];
                    else if (full[31:24] != 8'h03)
                        bad_frames <= bad_frames + 1;
                end
            end
        end
    end

    assign spi_miso = (bc >= 24 && bc < 32 && lat[23:16] == 8'h03)
                      ? mem[{lat_chip, lat[CAW-1:0]}][7 - (bc - 24)] : 1'b0;

    logic [7:0] hist [0:1023];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        ram_cnt_strap = strap;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!out_valid, "R1 out_valid", out_valid, 0);
        chk(ram1_cs_n && ram2_cs_n, "R1 chip selects", {ram1_cs_n, ram2_cs_n}, 3);
        chk(!spi_sclk, "R1 sclk", spi_sclk, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_sample(input int k, input logic strap);
        int d, r, n, sz, fs, o;
        logic [7:0] s, exp;
        logic fast;
        case (k % 5)
            0: d = 0;
            1: d = 255;
            2: d = 1;
            3: d = 128;
            default: d = (k * 37) & 255;
        endcase
        r    = (k / 3) % 8;
        fast = k[1];
        s    = 8'((k * 13 + 7) & 255);
        hist[k] = s;
        sz = strap ? (2 << CAW) : (1 << CAW);
        fs = sz >> (7 - r);
        o  = (d * fs) >> 8;
        exp = (k >= o) ? hist[k - o] : 8'h00;
        @(negedge clk);
        adc_word   = {s, 2'(k)};
        delay_code = 8'(d);
        range_code = 3'(r);
        rate_fast  = fast;
        if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0;
        n = 1;
        while (!out_valid && n < 600) begin
            @(negedge clk);
            n++;
        end
        // R9 latency, R2 stored byte, R4/R6/R7 read position
        chk(n == 131, "R9 latency", n - 1, 130);
        chk(out_sample == exp, "R4/R6/R7 delayed byte", out_sample, exp);
        @(negedge clk);
        chk(!out_valid, "R9 single pulse", out_valid, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 195000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int quiet_bad;
        // one chip
        do_reset(1'b0);
        for (int k = 0; k < 150; k++) do_sample(k, 1'b0);
        // R8 unselected tick ignored
        @(negedge clk);
        rate_fast = 1'b1;
        tick_slow = 1'b1;
        @(negedge clk);
        tick_slow = 1'b0;
        quiet_bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (out_valid || !ram1_cs_n || !ram2_cs_n) quiet_bad++;
        end
        chk(quiet_bad == 0, "R8 unselected tick", quiet_bad, 0);
        for (int k = 150; k < 300; k++) do_sample(k, 1'b0);
        // R5 second chip unused, R2/R3 frame formats
        chk(ram2_low == 0, "R5 ram2 unused", ram2_low, 0);
        chk(bad_frames == 0, "R2/R3 frame format", bad_frames, 0);

        // two chips
        do_reset(1'b1);
        for (int k = 0; k < 560; k++) do_sample(k, 1'b1);
        chk(ram2_low > 0, "R5 ram2 used", ram2_low, 1);
        chk(bad_frames == 0, "R2/R3 frame format", bad_frames, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule